// File: doc/BRIEF.md
# Temperature Status and Alert Logic

This block keeps the threshold and fault flags for a two-channel temperature monitor (one local sensor, one remote diode). It also drives an interrupt latch that is held apart from those flags. Each time the converter finishes a channel, it presents a signed result. The block compares that result with the channel's high and low limits and keeps a record of every violation. These violations only reach the host-visible status byte at a defined moment: the first bus clock edge after a bus stop condition. This keeps the status byte steady while a bus transaction is in progress. The remote-diode open-circuit flag follows a separate rule. It is sampled only when a conversion starts.

A host reads the status byte with a one-cycle read strobe. The read clears every flag whose condition has gone away, and leaves alone any flag whose condition is still present. The interrupt latch pulls `alert_n` low when a flag newly sets, provided the mask bit is clear. A status read does not release the latch. Only an explicit acknowledge pulse does. A configuration write sets the mask bit and a standby bit. Standby halts the converter and makes the block ignore conversion traffic.

Top module: `tsense_status_alert`

## Requirements
- R1: After a synchronous reset, `status_byte` is 00h, `busy` is 0, `alert_n` is 1 and `adc_run` is 1.
- R2: `status_byte` layout: bit 7 busy, bit 6 local high, bit 5 local low, bit 4 remote high, bit 3 remote low, bit 2 remote open, bits 1:0 always 0.
- R3: A result records a high violation when it is strictly greater than the high limit, and a low violation when it is strictly less than the low limit. Both comparisons use signed two's complement. A result equal to a limit records nothing. High and low violations accumulate, so both can be pending together.
- R4: The four limit flags change only in two cases. On the first `bus_clk_edge` after a `bus_stop`, they load every violation recorded since the last read. A status read can also change them.
- R5: A status read (`st_rd`) clears each limit flag whose channel's most recent result no longer violates that limit. It resets the pending record to the conditions that still persist.
- R6: The open flag loads `diode_open` at each accepted `conv_start`. A status read clears it only while `diode_open` is low. Otherwise it holds.
- R7: `busy` rises the cycle after an accepted `conv_start` and falls the cycle after the remote channel's done pulse (`res_done[1]`).
- R8: `alert_n` goes low in the same cycle that any status flag goes from 0 to 1 while the mask is clear. It stays low through status reads until an `alert_ack` pulse releases it. A new flag set wins over a simultaneous acknowledge.
- R9: A configuration write stores bit 0 as the alert mask. While the mask is 1, newly set flags do not assert `alert_n`.
- R10: A configuration write stores bit 1 as standby. Standby drives `adc_run` low. It also makes the block ignore `conv_start` and `res_done`, so `busy` does not rise, no violation is recorded and the open flag is not reloaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration byte (bit 0 mask, bit 1 standby) |
| conv_start | input | 1 | Converter begins a conversion cycle |
| res_done | input | 2 | Per-channel result valid pulse (bit 0 local, bit 1 remote) |
| res_temp | input | 16 | Signed results, local in [7:0], remote in [15:8] |
| lim_hi | input | 16 | Signed high limits, local in [7:0], remote in [15:8] |
| lim_lo | input | 16 | Signed low limits, local in [7:0], remote in [15:8] |
| diode_open | input | 1 | Remote diode path open-circuit indication |
| bus_stop | input | 1 | Bus stop condition seen |
| bus_clk_edge | input | 1 | Bus clock edge seen |
| st_rd | input | 1 | Status byte read strobe |
| alert_ack | input | 1 | Releases the interrupt latch |
| status_byte | output | 8 | Status flags per R2 |
| busy | output | 1 | Conversion in progress |
| adc_run | output | 1 | Converter enable, low in standby |
| alert_n | output | 1 | Active-low interrupt |

## Verification
The hardest state to reach is a set of pending violations that differs from both the visible flags and the persisting conditions. One example is a local high and a local low both recorded with only the low still true. Another is a read that lands between a stop and its following clock edge. Directed sequences create these states by running two conversions with opposite results before a refresh, then reading before and after a cool-down result. A long random phase then mixes reads, refreshes, acknowledges, mask changes and standby at arbitrary offsets, under a behavioural reference model that is checked every cycle.

// File: rtl/tsa_pkg.sv
package tsa_pkg;
  localparam int NCH    = 2;          // channel 0 local, channel 1 remote
  localparam int NLIM   = 2 * NCH;    // one high and one low flag per channel
  localparam int SW     = 8;          // status byte width
  localparam int CFG_W  = 8;          // configuration byte width
  localparam int CFG_MASK_BIT = 0;
  localparam int CFG_STBY_BIT = 1;
endpackage

// File: rtl/tsa_limit_cmp.sv
module tsa_limit_cmp #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic [TW-1:0] temp,
  input  logic [TW-1:0] hi_lim,
  input  logic [TW-1:0] lo_lim,
  output logic          ev_hi,
  output logic          ev_lo,
  output logic          cond_hi,
  output logic          cond_lo
);
  logic over, under;

  always_comb begin
    over  = $signed(temp) > $signed(hi_lim);
    under = $signed(temp) < $signed(lo_lim);
    ev_hi = take && over;
    ev_lo = take && under;
  end

  // Condition of the most recent accepted result, used when a read decides persistence
  always_ff @(posedge clk) begin
    if (rst) begin
      cond_hi <= 1'b0;
      cond_lo <= 1'b0;
    end else if (take) begin
      cond_hi <= over;
      cond_lo <= under;
    end
  end

  // R3
  cond_update_chk: assert property (@(posedge clk) disable iff (rst)
    !take |=> $stable({cond_hi, cond_lo}));
endmodule

// File: rtl/tsa_status.sv
module tsa_status #(
  parameter int NL = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NL-1:0] lim_ev,
  input  logic [NL-1:0] lim_cond,
  input  logic          start_ok,
  input  logic          last_ok,
  input  logic          diode_open,
  input  logic          st_rd,
  input  logic          bus_stop,
  input  logic          clk_edge,
  output logic [NL-1:0] lim_flag,
  output logic          open_flag,
  output logic          busy,
  output logic          set_req
);
  logic [NL-1:0] acc_q, acc_d, lim_d;
  logic          open_d, busy_d, armed_q, armed_d, refresh;

  always_comb begin
    refresh = clk_edge && armed_q;
    armed_d = bus_stop || (armed_q && !clk_edge);

    lim_d = lim_flag;
    if (refresh)    lim_d = acc_q;
    else if (st_rd) lim_d = lim_flag & lim_cond;

    acc_d = (st_rd ? lim_cond : acc_q) | lim_ev;

    open_d = open_flag;
    if (start_ok)   open_d = diode_open;
    else if (st_rd) open_d = open_flag & diode_open;

    busy_d = busy;
    if (start_ok)     busy_d = 1'b1;
    else if (last_ok) busy_d = 1'b0;

    set_req = |({lim_d, open_d} & ~{lim_flag, open_flag});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q     <= '0;
      lim_flag  <= '0;
      open_flag <= 1'b0;
      busy      <= 1'b0;
      armed_q   <= 1'b0;
    end else begin
      acc_q     <= acc_d;
      lim_flag  <= lim_d;
      open_flag <= open_d;
      busy      <= busy_d;
      armed_q   <= armed_d;
    end
  end

  // R1
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> (lim_flag == '0 && !open_flag && !busy));
  // R4
  lim_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!refresh && !st_rd) |=> $stable(lim_flag));
  // R5
  rd_noset_chk: assert property (@(posedge clk) disable iff (rst)
    (st_rd && !refresh) |=> ((lim_flag & ~$past(lim_flag)) == '0));
  // R6
  open_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!start_ok && !st_rd) |=> $stable(open_flag));
  // R7
  busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start_ok));
endmodule

// File: rtl/tsa_alert.sv
module tsa_alert (
  input  logic clk,
  input  logic rst,
  input  logic set_req,
  input  logic mask,
  input  logic ack,
  output logic alert_n
);
  logic alert_q;

  always_ff @(posedge clk) begin
    if (rst)                  alert_q <= 1'b0;
    else if (set_req && !mask) alert_q <= 1'b1;
    else if (ack)             alert_q <= 1'b0;
  end

  assign alert_n = ~alert_q;

  // R8
  ack_only_chk: assert property (@(posedge clk) disable iff (rst)
    (alert_q && !ack) |=> alert_q);
  // R9
  rise_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(alert_q) |-> $past(set_req && !mask));
endmodule

// File: rtl/tsense_status_alert.sv
module tsense_status_alert
  import tsa_pkg::*;
#(
  parameter int TW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              conv_start,
  input  logic [NCH-1:0]    res_done,
  input  logic [NCH*TW-1:0] res_temp,
  input  logic [NCH*TW-1:0] lim_hi,
  input  logic [NCH*TW-1:0] lim_lo,
  input  logic              diode_open,
  input  logic              bus_stop,
  input  logic              bus_clk_edge,
  input  logic              st_rd,
  input  logic              alert_ack,
  output logic [SW-1:0]     status_byte,
  output logic              busy,
  output logic              adc_run,
  output logic              alert_n
);
  localparam int PAD = SW - 2 - NLIM;

  logic            mask_q, stby_q;
  logic            start_ok;
  logic [NCH-1:0]  take;
  logic [NLIM-1:0] lim_ev, lim_cond, lim_flag;
  logic            open_flag, set_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= 1'b0;
      stby_q <= 1'b0;
    end else if (cfg_wr) begin
      mask_q <= cfg_wdata[CFG_MASK_BIT];
      stby_q <= cfg_wdata[CFG_STBY_BIT];
    end
  end

  assign adc_run  = ~stby_q;
  assign start_ok = conv_start && !stby_q;
  assign take     = stby_q ? '0 : res_done;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    tsa_limit_cmp #(.TW(TW)) u_cmp (
      .clk     (clk),
      .rst     (rst),
      .take    (take[ch]),
      .temp    (res_temp[ch*TW +: TW]),
      .hi_lim  (lim_hi[ch*TW +: TW]),
      .lo_lim  (lim_lo[ch*TW +: TW]),
      .ev_hi   (lim_ev[NLIM-1-2*ch]),
      .ev_lo   (lim_ev[NLIM-2-2*ch]),
      .cond_hi (lim_cond[NLIM-1-2*ch]),
      .cond_lo (lim_cond[NLIM-2-2*ch])
    );
  end

  tsa_status #(.NL(NLIM)) u_status (
    .clk        (clk),
    .rst        (rst),
    .lim_ev     (lim_ev),
    .lim_cond   (lim_cond),
    .start_ok   (start_ok),
    .last_ok    (take[NCH-1]),
    .diode_open (diode_open),
    .st_rd      (st_rd),
    .bus_stop   (bus_stop),
    .clk_edge   (bus_clk_edge),
    .lim_flag   (lim_flag),
    .open_flag  (open_flag),
    .busy       (busy),
    .set_req    (set_req)
  );

  tsa_alert u_alert (
    .clk     (clk),
    .rst     (rst),
    .set_req (set_req),
    .mask    (mask_q),
    .ack     (alert_ack),
    .alert_n (alert_n)
  );

  assign status_byte = {busy, lim_flag, open_flag, {PAD{1'b0}}};

  // R10
  stby_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (stby_q && !busy) |=> !busy);
endmodule

// File: tb/tsense_status_alert_bench.sv
module tsense_status_alert_bench;
  logic clk = 1'b0, rst = 1'b1;
  logic cfg_wr = 0, conv_start = 0, diode_open = 0, bus_stop = 0, bus_clk_edge = 0;
  logic st_rd = 0, alert_ack = 0;
  logic [7:0] cfg_wdata = 0;
  logic [1:0] res_done = 0;
  logic [15:0] res_temp = 0, lim_hi = 0, lim_lo = 0;
  logic [7:0] status_byte;
  logic busy, adc_run, alert_n;

  int checks = 0, errors = 0;
  bit finished = 0, live = 0;

  always #2 clk = ~clk;

  tsense_status_alert u_tsense_status_alert (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .conv_start(conv_start), .res_done(res_done), .res_temp(res_temp),
    .lim_hi(lim_hi), .lim_lo(lim_lo), .diode_open(diode_open),
    .bus_stop(bus_stop), .bus_clk_edge(bus_clk_edge), .st_rd(st_rd),
    .alert_ack(alert_ack), .status_byte(status_byte), .busy(busy),
    .adc_run(adc_run), .alert_n(alert_n));

  // ---------------- behavioural reference ----------------
  bit m_pend[4], m_cond[4], m_flag[4];
  bit m_open, m_busy, m_alert, m_armed, m_mask, m_stby;

  always @(posedge clk) begin : model
    bit ev[4], nf[4], nopen, up, do_ref;
    int t[2], h[2], l[2];
    if (rst) begin
      for (int i = 0; i < 4; i++) begin m_pend[i] = 0; m_cond[i] = 0; m_flag[i] = 0; end
      m_open = 0; m_busy = 0; m_alert = 0; m_armed = 0; m_mask = 0; m_stby = 0;
    end else begin
      for (int c = 0; c < 2; c++) begin
        t[c] = int'($signed(res_temp[c*8 +: 8]));
        h[c] = int'($signed(lim_hi[c*8 +: 8]));
        l[c] = int'($signed(lim_lo[c*8 +: 8]));
        ev[3-2*c] = res_done[c] && !m_stby && (t[c] > h[c]);
        ev[2-2*c] = res_done[c] && !m_stby && (t[c] < l[c]);
      end
      do_ref = bus_clk_edge && m_armed;
      up = 0;
      for (int i = 0; i < 4; i++) begin
        nf[i] = do_ref ? m_pend[i] : (st_rd ? (m_flag[i] && m_cond[i]) : m_flag[i]);
        if (nf[i] && !m_flag[i]) up = 1;
        m_pend[i] = (st_rd ? m_cond[i] : m_pend[i]) || ev[i];
        m_flag[i] = nf[i];
      end
      for (int c = 0; c < 2; c++)
        if (res_done[c] && !m_stby) begin
          m_cond[3-2*c] = t[c] > h[c];
          m_cond[2-2*c] = t[c] < l[c];
        end
      nopen = m_open;
      if (conv_start && !m_stby) nopen = diode_open;
      else if (st_rd) nopen = m_open && diode_open;
      if (nopen && !m_open) up = 1;
      m_open = nopen;
      if (conv_start && !m_stby) m_busy = 1;
      else if (res_done[1] && !m_stby) m_busy = 0;
      m_armed = bus_stop || (m_armed && !bus_clk_edge);
      if (up && !m_mask) m_alert = 1;
      else if (alert_ack) m_alert = 0;
      if (cfg_wr) begin m_mask = cfg_wdata[0]; m_stby = cfg_wdata[1]; end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) if (live && !rst) begin
    automatic logic [7:0] e = {m_busy, m_flag[3], m_flag[2], m_flag[1], m_flag[0], m_open, 2'b00};
    chk(status_byte[6:3] == e[6:3], "R4 limit flags", status_byte[6:3], e[6:3]);
    chk(status_byte[2] == e[2], "R6 open flag", status_byte[2], e[2]);
    chk(status_byte[7] == e[7] && busy == m_busy, "R7 busy", {status_byte[7], busy}, {e[7], m_busy});
    chk(status_byte[1:0] == 2'b00, "R2 pad bits", status_byte[1:0], 0);
    chk(alert_n == !m_alert, "R8 alert", alert_n, !m_alert);
    chk(adc_run == !m_stby, "R10 adc_run", adc_run, !m_stby);
  end

  task automatic tick();
    @(posedge clk); @(negedge clk);
    cfg_wr = 0; conv_start = 0; res_done = 0; bus_stop = 0;
    bus_clk_edge = 0; st_rd = 0; alert_ack = 0;
  endtask

  task automatic conv(input logic [7:0] lt, input logic [7:0] rt, input bit op);
    diode_open = op; conv_start = 1; tick(); tick();
    res_temp[7:0] = lt; res_done = 2'b01; tick();
    res_temp[15:8] = rt; res_done = 2'b10; tick();
  endtask

  task automatic refresh(); bus_stop = 1; tick(); tick(); bus_clk_edge = 1; tick(); endtask
  task automatic rd();      st_rd = 1; tick(); endtask
  task automatic ack();     alert_ack = 1; tick(); endtask
  task automatic cfg(input logic [7:0] v); cfg_wr = 1; cfg_wdata = v; tick(); endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    lim_hi = {8'd80, 8'd70};
    lim_lo = {8'd5, 8'd10};
    repeat (3) @(negedge clk);
    rst = 0; live = 1; tick();
    chk(status_byte == 8'h00 && alert_n && adc_run && !busy, "R1 reset state",
        {status_byte, alert_n, adc_run, busy}, 11'h006);

    conv(8'd25, 8'd30, 0); refresh();
    chk(status_byte == 8'h00, "R3 in-range results", status_byte, 0);

    conv_start = 1; tick();
    chk(status_byte == 8'h80 && busy, "R7 busy set (R2 bit 7)", status_byte, 8'h80);
    tick(); res_temp[7:0] = 8'd71; res_done = 2'b01; tick();
    res_done = 2'b10; tick();
    chk(status_byte == 8'h00, "R4 not visible before refresh", status_byte, 0);
    bus_stop = 1; tick(); tick();
    chk(status_byte == 8'h00, "R4 stop alone does not refresh", status_byte, 0);
    bus_clk_edge = 1; tick();
    chk(status_byte == 8'h40 && !alert_n, "R4 local high visible, R8 alert", {status_byte, alert_n}, 9'h080);

    rd();
    chk(status_byte == 8'h40, "R5 persisting flag kept", status_byte, 8'h40);
    conv(8'd40, 8'd30, 0); rd();
    chk(status_byte == 8'h00 && !alert_n, "R5 cleared, R8 latch survives read", {status_byte, alert_n}, 0);
    ack();
    chk(alert_n == 1, "R8 ack releases", alert_n, 1);

    conv(8'd70, 8'd80, 0); refresh();
    chk(status_byte == 8'h00, "R3 equal to limit", status_byte, 0);

    conv(8'd75, 8'd5, 0); conv(8'd5, 8'd81, 0); refresh();
    chk(status_byte == 8'h70, "R3 high and low accumulate", status_byte, 8'h70);
    rd();
    chk(status_byte == 8'h30, "R5 only persisting flags remain", status_byte, 8'h30);
    conv(8'd30, 8'd30, 0); rd(); ack();
    chk(status_byte == 8'h00 && alert_n, "R5 all clear", {status_byte, alert_n}, 1);

    lim_lo[7:0] = 8'hF6;
    conv(8'h90, 8'd30, 0); refresh();
    chk(status_byte == 8'h20, "R3 signed compare", status_byte, 8'h20);
    conv(8'd0, 8'd30, 0); rd(); ack();

    diode_open = 1; conv_start = 1; tick();
    chk(status_byte == 8'h84 && !alert_n, "R6 open loads at start", {status_byte, alert_n}, 9'h108);
    tick(); res_done = 2'b11; res_temp = {8'd30, 8'd30}; tick();
    rd();
    chk(status_byte[2] == 1, "R6 open held while fault present", status_byte[2], 1);
    diode_open = 0; rd(); ack();
    chk(status_byte[2] == 0 && alert_n, "R6 open cleared by read", {status_byte[2], alert_n}, 1);

    cfg(8'h01);
    conv(8'd90, 8'd30, 0); refresh();
    chk(status_byte == 8'h40 && alert_n, "R9 masked alert", {status_byte, alert_n}, 9'h081);
    conv(8'd30, 8'd30, 0); rd(); cfg(8'h00);

    cfg(8'h02);
    chk(adc_run == 0, "R10 standby halts adc", adc_run, 0);
    conv(8'd90, 8'd90, 1); refresh();
    chk(status_byte == 8'h00 && !busy && alert_n, "R10 standby ignores conversions",
        {status_byte, busy, alert_n}, 1);
    cfg(8'h00); diode_open = 0;

    for (int n = 0; n < 4000; n++) begin
      res_temp   = {8'($urandom_range(0, 100)), 8'($urandom_range(0, 90))};
      res_done   = 2'($urandom_range(0, 3)) & {2{$urandom_range(0, 3) == 0}};
      conv_start = $urandom_range(0, 9) == 0;
      diode_open = $urandom_range(0, 5) == 0;
      bus_stop   = $urandom_range(0, 7) == 0;
      bus_clk_edge = $urandom_range(0, 3) == 0;
      st_rd      = $urandom_range(0, 11) == 0;
      alert_ack  = $urandom_range(0, 15) == 0;
      cfg_wr     = $urandom_range(0, 63) == 0;
      cfg_wdata  = 8'($urandom_range(0, 255)) & {7'h7F, ($urandom_range(0, 3) == 0)};
      tick();
    end

    live = 0;
    finish_run();
  end
endmodule